// File: doc/BRIEF.md
# Write-Only Clock Configuration Receiver

This block receives configuration for a clock generator over a two-wire serial bus and holds it in registers. It is a slave receiver that handles write transfers only. The bus clock and data lines enter through two-flop synchronizers, and the block runs on a faster system clock. START and STOP conditions are found as data edges while the bus clock is high. An acknowledge pull-down drives the open-drain data line.

A transfer always has eleven bytes. The first is the slave address with the write bit, and it must equal 8'hD2. Two header bytes follow and are acknowledged but not used. Eight data bytes come last. Only data bytes 0, 1, 2, 3 and 5 contain fields, and each field is committed when its byte is complete.

The outputs are these decoded fields:
- a frequency code and a bit that chooses between the strap code and the register code,
- a two-bit operating mode,
- several groups of output-enable bits. Each enable is the complement of a low-active disable, so 1 means the output runs, and every enable resets to 1.

Top module: `clkcfg_wr_rx`

## Requirements
- R1: After a synchronous reset every enable bit is 1, freq_code is 0, use_reg_code is 0, op_mode is 2'b00 (normal) and sda_pull_low is 0.
- R2: The only address accepted is 8'hD2, whose least significant bit 0 means write. For an accepted frame the block pulls SDA low during the ninth SCL pulse of each of the eleven bytes.
- R3: If the address byte is anything other than 8'hD2, no byte of that transfer is acknowledged and no register changes. The block stays off the bus until the next START.
- R4: After the address come the command byte and the count byte, then data bytes 0 to 7. The values of the command and count bytes have no effect on any output.
- R5: Bits are received MSB first. The address sent with its bits in reversed order (8'h4B) is not accepted.
- R6: Data byte 0 sets the following fields: freq_code = {bit2, bit6, bit5, bit4}, use_reg_code = bit3, op_mode = bits 1:0. The mode encoding is 00 normal, 01 test bypass, 10 spread on, 11 all outputs high-impedance.
- R7: Data byte 1 bits 3:0 go to cpu_sdr_en[3:0], which is {free SDRAM, CPU2, CPU1, free CPU}. Data byte 2 bits 6:0 go to pci_en[6:0], which is {free PCI, PCI5..PCI0}. A 0 in any of these bits disables its output.
- R8: Data byte 3 bits 5:0 go to periph_en, which is {48 MHz, 24 MHz, SDRAM group 3..0}. Data byte 5 bits 5, 4, 1, 0 go to ref_en[3:0], which is {free APIC, APIC, REF1, REF0}. Data bytes 4, 6 and 7 and all other bits are discarded.
- R9: Registers change only when a full 8-bit data byte has been received. If a STOP or a repeated START arrives in the middle of a byte, the partial byte is discarded. Bytes completed before it remain.
- R10: A byte sent after the eleventh byte of a frame is not acknowledged and does not change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line, as seen on the wire |
| sda_pull_low | output | 1 | 1 pulls the open-drain data line low (acknowledge) |
| use_reg_code | output | 1 | 1: frequency from freq_code, 0: from strap pins |
| freq_code | output | 4 | Register frequency code |
| op_mode | output | 2 | Operating mode |
| cpu_sdr_en | output | 4 | Enables for CPU and free SDRAM clocks |
| pci_en | output | 7 | Enables for PCI clocks |
| periph_en | output | 6 | Enables for 48/24 MHz and SDRAM groups |
| ref_en | output | 4 | Enables for APIC and reference clocks |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, an eleven-byte frame with three header bytes, and address 8'hD2. It drives the bus clock with a quarter period of eight system clocks. That is long enough for the synchronizer and edge detector to settle in every bus phase, so acknowledge timing can be sampled at fixed points. Because the frame length is eleven bytes, the bench can reach the overrun byte and mid-byte STOP and repeated START cases within a few thousand cycles each.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK_WAIT,
    ST_ACK_DRIVE,
    ST_IGNORE
  } rx_state_t;
endpackage

// File: rtl/cfgrx_sync.sv
module cfgrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 1'b1;
        else if (g == 0) chain[g] <= d_in;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/cfgrx_frame.sv
module cfgrx_frame
  import cfgrx_pkg::*;
#(
  parameter logic [7:0] SLAVE_ADDR  = 8'hD2,
  parameter int         FRAME_BYTES = 11,
  parameter int         HDR_BYTES   = 3,
  localparam int        CNT_W       = $clog2(FRAME_BYTES + 1),
  localparam int        IDX_W       = $clog2(FRAME_BYTES - HDR_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_s,
  input  logic             sda_s,
  output logic             sda_low,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);
  rx_state_t        state;
  logic             scl_d, sda_d;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] byte_cnt;
  logic [6:0]       shreg;
  logic             scl_rise, scl_fall, start_c, stop_c;
  logic [7:0]       full_byte;
  logic [CNT_W-1:0] rel_idx;

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_c   = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c    = scl_s & scl_d & ~sda_d & sda_s;
  assign full_byte = {shreg, sda_s};
  assign rel_idx   = byte_cnt - CNT_W'(HDR_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      shreg    <= '0;
      sda_low  <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_c) begin
        state    <= ST_RECV;
        bit_cnt  <= '0;
        byte_cnt <= '0;
        sda_low  <= 1'b0;
      end else if (stop_c) begin
        state   <= ST_IDLE;
        sda_low <= 1'b0;
      end else begin
        case (state)
          ST_RECV: if (scl_rise) begin
            shreg   <= full_byte[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              if (byte_cnt == '0) begin
                if (full_byte == SLAVE_ADDR) begin
                  state    <= ST_ACK_WAIT;
                  byte_cnt <= byte_cnt + 1'b1;
                end else begin
                  state <= ST_IGNORE;
                end
              end else if (byte_cnt < CNT_W'(FRAME_BYTES)) begin
                state    <= ST_ACK_WAIT;
                byte_cnt <= byte_cnt + 1'b1;
                if (byte_cnt >= CNT_W'(HDR_BYTES)) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= rel_idx[IDX_W-1:0];
                  wr_data <= full_byte;
                end
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ACK_WAIT: if (scl_fall) begin
            sda_low <= 1'b1;
            state   <= ST_ACK_DRIVE;
          end
          ST_ACK_DRIVE: if (scl_fall) begin
            sda_low <= 1'b0;
            state   <= ST_RECV;
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_ack_with_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low) |-> !scl_s);
  a_r3_silent_when_ignoring: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_low);
  a_r9_commit_after_rise: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(scl_s && !scl_d));
endmodule

// File: rtl/cfgrx_regs.sv
module cfgrx_regs #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  output logic             use_reg_code,
  output logic [3:0]       freq_code,
  output logic [1:0]       op_mode,
  output logic [3:0]       cpu_sdr_en,
  output logic [6:0]       pci_en,
  output logic [5:0]       periph_en,
  output logic [3:0]       ref_en
);
  logic msb_unused;
  assign msb_unused = wr_data[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      use_reg_code <= 1'b0;
      freq_code    <= '0;
      op_mode      <= 2'b00;
      cpu_sdr_en   <= '1;
      pci_en       <= '1;
      periph_en    <= '1;
      ref_en       <= '1;
    end else if (wr_en) begin
      if (wr_idx == IDX_W'(0)) begin
        freq_code    <= {wr_data[2], wr_data[6:4]};
        use_reg_code <= wr_data[3];
        op_mode      <= wr_data[1:0];
      end
      if (wr_idx == IDX_W'(1)) cpu_sdr_en <= wr_data[3:0];
      if (wr_idx == IDX_W'(2)) pci_en     <= wr_data[6:0];
      if (wr_idx == IDX_W'(3)) periph_en  <= wr_data[5:0];
      if (wr_idx == IDX_W'(5)) ref_en     <= {wr_data[5:4], wr_data[1:0]};
    end
  end

  a_r1_defaults_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (op_mode == 2'b00 && freq_code == 4'h0 && !use_reg_code &&
                    &cpu_sdr_en && &pci_en && &periph_en && &ref_en));
  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable({use_reg_code, freq_code, op_mode, cpu_sdr_en,
                        pci_en, periph_en, ref_en}));
endmodule

// File: rtl/clkcfg_wr_rx.sv
module clkcfg_wr_rx #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] SLAVE_ADDR  = 8'hD2,
  parameter int         FRAME_BYTES = 11,
  parameter int         HDR_BYTES   = 3,
  localparam int        IDX_W       = $clog2(FRAME_BYTES - HDR_BYTES)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull_low,
  output logic       use_reg_code,
  output logic [3:0] freq_code,
  output logic [1:0] op_mode,
  output logic [3:0] cpu_sdr_en,
  output logic [6:0] pci_en,
  output logic [5:0] periph_en,
  output logic [3:0] ref_en
);
  logic             scl_s, sda_s, wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  cfgrx_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst(rst), .d_in(scl_in), .q_out(scl_s));
  cfgrx_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst(rst), .d_in(sda_in), .q_out(sda_s));

  cfgrx_frame #(
    .SLAVE_ADDR(SLAVE_ADDR), .FRAME_BYTES(FRAME_BYTES), .HDR_BYTES(HDR_BYTES)
  ) u_frame (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .sda_low(sda_pull_low), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

  cfgrx_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .use_reg_code(use_reg_code), .freq_code(freq_code), .op_mode(op_mode),
    .cpu_sdr_en(cpu_sdr_en), .pci_en(pci_en), .periph_en(periph_en),
    .ref_en(ref_en));
endmodule

// File: tb/sim_clkcfg_wr_rx.sv
module sim_clkcfg_wr_rx;
  localparam int Q = 8;
  logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull_low, use_reg_code;
  logic [3:0] freq_code, cpu_sdr_en, ref_en;
  logic [1:0] op_mode;
  logic [6:0] pci_en;
  logic [5:0] periph_en;
  logic sda_line;
  logic [27:0] obs;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  assign sda_line = sda_m & ~sda_pull_low;
  assign obs = {use_reg_code, freq_code, op_mode, cpu_sdr_en, pci_en, periph_en, ref_en};

  always #10 clk = ~clk;

  clkcfg_wr_rx u0 (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull_low(sda_pull_low), .use_reg_code(use_reg_code),
    .freq_code(freq_code), .op_mode(op_mode), .cpu_sdr_en(cpu_sdr_en),
    .pci_en(pci_en), .periph_en(periph_en), .ref_en(ref_en));

  localparam logic [27:0] DEF_OBS = {1'b0, 4'h0, 2'b00, 4'hF, 7'h7F, 6'h3F, 4'hF};
  // {data bytes 0..5, expected {use, code, mode, cpu_sdr, pci, periph, ref}}
  localparam logic [75:0] VEC [4] = '{
    {48'h00_00_00_00_00_00, 1'b0, 4'h0, 2'b00, 4'h0, 7'h00, 6'h00, 4'h0},
    {48'hFF_FF_FF_FF_FF_FF, 1'b1, 4'hF, 2'b11, 4'hF, 7'h7F, 6'h3F, 4'hF},
    {48'h5A_05_2A_15_AA_21, 1'b1, 4'b0101, 2'b10, 4'b0101, 7'b0101010, 6'b010101, 4'b1001},
    {48'h27_0A_41_2C_00_12, 1'b0, 4'b1010, 2'b11, 4'b1010, 7'b1000001, 6'b101100, 4'b0110}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = (sda_line == 1'b0);
    wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_frame(input logic [7:0] addr, input logic [7:0] cmd,
                            input logic [7:0] cnt, input logic [63:0] data,
                            output int acks);
    bit a;
    acks = 0;
    bus_start();
    send_byte(addr, a); acks += int'(a);
    send_byte(cmd, a);  acks += int'(a);
    send_byte(cnt, a);  acks += int'(a);
    for (int k = 7; k >= 0; k--) begin
      send_byte(data[k*8 +: 8], a); acks += int'(a);
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int acks;
    bit a;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset values
    chk("R1 outputs", 32'(obs), 32'(DEF_OBS));
    chk("R1 ack idle", 32'(sda_pull_low), 32'd0);

    // Table walk: R2 acks, R4 varying header bytes, R6 R7 R8 field mapping
    for (int v = 0; v < 4; v++) begin
      send_frame(8'hD2, 8'(v * 37 + 5), 8'(8'hF0 ^ v), {VEC[v][75:28], 16'hA55A}, acks);
      chk("R2 acks per frame", 32'(acks), 32'd11);
      chk("R4 R6 R7 R8 fields", 32'(obs), 32'(VEC[v][27:0]));
    end

    // R3: wrong address, R5: bit-reversed address
    send_frame(8'hD4, 8'h00, 8'h00, 64'h0, acks);
    chk("R3 no ack wrong addr", 32'(acks), 32'd0);
    chk("R3 regs unchanged", 32'(obs), 32'(VEC[3][27:0]));
    send_frame(8'h4B, 8'h00, 8'h00, 64'h0, acks);
    chk("R5 reversed addr rejected", 32'(acks), 32'd0);
    chk("R5 regs unchanged", 32'(obs), 32'(VEC[3][27:0]));
    send_frame(8'hD3, 8'h00, 8'h00, 64'h0, acks);
    chk("R3 read-bit addr rejected", 32'(acks), 32'd0);

    // R9: STOP inside data byte 1
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
    send_byte(8'h00, a);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    chk("R9 partial after stop", 32'(obs),
        32'({1'b0, 4'h0, 2'b00, 4'b1010, 7'b1000001, 6'b101100, 4'b0110}));

    // R9: repeated START inside data byte 1, then new address accepted
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h11, a); send_byte(8'h22, a);
    send_byte(8'h5A, a);
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    send_byte(8'hD2, a);
    chk("R9 ack after restart", 32'(a), 32'd1);
    bus_stop();
    chk("R9 partial after restart", 32'(obs),
        32'({1'b1, 4'b0101, 2'b10, 4'b1010, 7'b1000001, 6'b101100, 4'b0110}));

    // R10: byte past the eleventh
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
    for (int k = 7; k >= 0; k--) send_byte(VEC[2][28 + ((k >= 2) ? (k-2)*8 : 0) +: 8], a);
    send_byte(8'h00, a);
    chk("R10 no ack on extra byte", 32'(a), 32'd0);
    bus_stop();
    chk("R10 extra byte no effect", 32'(obs), 32'(VEC[2][27:0]));

    // R3: recovery at next START after a mismatch
    send_frame(8'hD2, 8'h00, 8'h00, {VEC[3][75:28], 16'h0000}, acks);
    chk("R3 recovery acks", 32'(acks), 32'd11);

    // R1: reset in the middle of operation
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 outputs after mid reset", 32'(obs), 32'(DEF_OBS));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule